// File: doc/BRIEF.md
# Instruction Fetch Guard

This block sits on the read path between a small processor core and its memory. Every access carries a flag that says whether it is an instruction fetch or a data read. For a fetch whose address falls inside a fixed, protected firmware RAM window, the block replaces the returned read word with all zeros. All zeros is an illegal instruction encoding, so the core takes its trap instead of running code from that window. Data reads and writes are never altered.

Software can also mark a second address range as non-executable, typically the application stack. It writes a lower and an upper bound and then sets the enable bit. From then on, fetches that land inside that inclusive range are blocked as well. Enabling is one-way. The enable bit cannot be cleared, and the bound registers stop accepting writes once the guard is on. A sticky status bit records that at least one fetch has been blocked. Only reset clears it.

Top module: `fetch_guard`

## Requirements
- R1: A fetch (`cpu_valid`=1, `cpu_instr`=1, `mem_ready`=1) whose address lies in FW_BASE to FW_BASE+FW_SIZE-1, both ends included, returns `cpu_rdata`=0 in that same cycle, whatever the enable state.
- R2: While the guard is enabled, a fetch whose address satisfies lower <= addr <= upper returns `cpu_rdata`=0 in that same cycle.
- R3: While the guard is disabled, a fetch inside the programmed range and outside the firmware window returns `mem_rdata` unchanged.
- R4: A data read (`cpu_instr`=0) returns `mem_rdata` unchanged, including reads inside either protected region. A fetch outside both regions also returns `mem_rdata` unchanged.
- R5: If the upper bound is below the lower bound, the programmable range blocks no address.
- R6: Register offset 0 (`reg_addr`=0), bit 0, is the enable. Writing 1 sets it. After it is set, writing 0 leaves it at 1 when read back.
- R7: Offset 1 holds the lower bound and offset 2 holds the upper bound. Both can be written while the guard is disabled. Once it is enabled, writes to them are ignored and their read-back values are unchanged.
- R8: Offset 3, bit 0, is the violation flag. It reads 1 from the cycle after the first blocked fetch and stays 1 until reset.
- R9: After reset, all four registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| cpu_valid | input | 1 | Core access in progress |
| cpu_instr | input | 1 | Access is an instruction fetch |
| cpu_addr | input | AW | Access address |
| mem_ready | input | 1 | Memory read data valid this cycle |
| mem_rdata | input | DW | Read word from memory |
| cpu_rdata | output | DW | Read word to core, zeroed on a blocked fetch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |

## Verification
The bench builds the block with AW=16, DW=32, FW_BASE=0x1000 and FW_SIZE=0x0800. With these values the firmware window is small. The words just below it, at its first address, at its last address and just above it can all be reached in a few fetches. The memory model returns {addr, ~addr}, which is never zero, so any substitution is visible. The bench runs the programmable range before enable, after enable, after locked writes, and with an inverted range. It also applies a second reset to show the sticky flag clearing.

// File: rtl/fetch_guard_pkg.sv
package fetch_guard_pkg;

  typedef enum logic [1:0] {
    GREG_CTRL = 2'd0,
    GREG_LOW  = 2'd1,
    GREG_HIGH = 2'd2,
    GREG_STAT = 2'd3
  } greg_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned STAT_VIOL_BIT = 0;

endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fg_range_match.sv
module fg_range_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  always_comb begin
    hit = (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
  import fetch_guard_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          viol_set,
  output logic          guard_en,
  output logic [AW-1:0] rng_lo,
  output logic [AW-1:0] rng_hi,
  output logic [DW-1:0] reg_rdata
);
  logic          en_q, en_d, en_ce;
  logic [AW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic          lo_ce, hi_ce;
  logic          viol_q, viol_d, viol_ce;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    en_ce   = reg_we && (reg_addr == GREG_CTRL) && reg_wdata[CTRL_EN_BIT] && !en_q;
    en_d    = 1'b1;
    lo_ce   = reg_we && (reg_addr == GREG_LOW)  && !en_q;
    lo_d    = reg_wdata[AW-1:0];
    hi_ce   = reg_we && (reg_addr == GREG_HIGH) && !en_q;
    hi_d    = reg_wdata[AW-1:0];
    viol_ce = viol_set && !viol_q;
    viol_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      viol_q <= 1'b0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (lo_ce)   lo_q   <= lo_d;
      if (hi_ce)   hi_q   <= hi_d;
      if (viol_ce) viol_q <= viol_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      GREG_CTRL: reg_rdata[CTRL_EN_BIT]   = en_q;
      GREG_LOW:  reg_rdata[AW-1:0]        = lo_q;
      GREG_HIGH: reg_rdata[AW-1:0]        = hi_q;
      default:   reg_rdata[STAT_VIOL_BIT] = viol_q;
    endcase
  end

  assign guard_en = en_q;
  assign rng_lo   = lo_q;
  assign rng_hi   = hi_q;

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni) en_q |=> en_q);

  // R7
  bounds_locked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    en_q |=> ($stable(lo_q) && $stable(hi_q)));

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni) viol_q |=> viol_q);

  // R8
  viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni) viol_set |=> viol_q);
endmodule

// File: rtl/fg_fetch_filter.sv
module fg_fetch_filter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cpu_valid,
  input  logic          cpu_instr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          fw_hit,
  input  logic          usr_hit,
  input  logic          guard_en,
  output logic [DW-1:0] cpu_rdata,
  output logic          viol_set
);
  logic fetch_beat;
  logic block;

  always_comb begin
    fetch_beat = cpu_valid && cpu_instr && mem_ready;
    block      = cpu_instr && (fw_hit || (guard_en && usr_hit));
    cpu_rdata  = block ? '0 : mem_rdata;
    viol_set   = fetch_beat && block;
  end

  // R1
  fw_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_valid && cpu_instr && mem_ready && fw_hit) |-> (cpu_rdata == '0));

  // R2
  usr_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_valid && cpu_instr && mem_ready && guard_en && usr_hit) |-> (cpu_rdata == '0));

  // R4
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_valid && !cpu_instr && mem_ready) |-> (cpu_rdata == mem_rdata));

  // R3
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_valid && mem_ready && !guard_en && !fw_hit) |-> (cpu_rdata == mem_rdata));
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned FW_BASE = 32'h0001_0000,
  parameter int unsigned FW_SIZE = 32'h0000_0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_instr,
  input  logic [AW-1:0] cpu_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam logic [AW-1:0] FW_LO = AW'(FW_BASE);
  localparam logic [AW-1:0] FW_HI = AW'(FW_BASE + FW_SIZE - 1);
  localparam int unsigned   NREG  = 2;

  logic            rst_sync_n;
  logic            guard_en, viol_set;
  logic [AW-1:0]   rng_lo, rng_hi;
  logic [AW-1:0]   bnd_lo [NREG];
  logic [AW-1:0]   bnd_hi [NREG];
  logic [NREG-1:0] hits;

  fg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fg_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .viol_set  (viol_set),
    .guard_en  (guard_en),
    .rng_lo    (rng_lo),
    .rng_hi    (rng_hi),
    .reg_rdata (reg_rdata)
  );

  assign bnd_lo[0] = FW_LO;
  assign bnd_hi[0] = FW_HI;
  assign bnd_lo[1] = rng_lo;
  assign bnd_hi[1] = rng_hi;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    fg_range_match #(.AW(AW)) u_match (
      .addr (cpu_addr),
      .lo   (bnd_lo[g]),
      .hi   (bnd_hi[g]),
      .hit  (hits[g])
    );
  end

  fg_fetch_filter #(.DW(DW)) u_filter (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .cpu_valid (cpu_valid),
    .cpu_instr (cpu_instr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .fw_hit    (hits[0]),
    .usr_hit   (hits[1]),
    .guard_en  (guard_en),
    .cpu_rdata (cpu_rdata),
    .viol_set  (viol_set)
  );

  // R5
  inverted_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rng_hi < rng_lo) |-> !hits[1]);
endmodule

// File: tb/fetch_guard_tb_top.sv
module fetch_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_valid, cpu_instr, mem_ready;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] mem_rdata, cpu_rdata;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = {cpu_addr, ~cpu_addr};

  fetch_guard #(.AW(AW), .DW(DW), .FW_BASE(32'h1000), .FW_SIZE(32'h0800)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_instr(cpu_instr), .cpu_addr(cpu_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic note(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access beat, expected word pushed to scoreboard
  task automatic access(bit instr, logic [AW-1:0] addr, bit blocked, string tag);
    sb_item_t it;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_instr = instr; cpu_addr = addr; mem_ready = 1'b1;
    it.exp = blocked ? '0 : {addr, ~addr};
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_instr = 1'b0; mem_ready = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (cpu_valid && mem_ready) begin
        if (sb_q.size() == 0) begin
          note(1'b0, "scoreboard underflow", cpu_rdata, '0);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          note(cpu_rdata === it.exp, it.tag, cpu_rdata, it.exp);
        end
      end
    end
  end

  task automatic reg_write(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_expect(logic [1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    note(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    cpu_valid = 0; cpu_instr = 0; cpu_addr = '0; mem_ready = 0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    do_reset();

    for (int i = 0; i < 4; i++) reg_expect(2'(i), '0, "R9 reset value");

    access(1, 16'h1000, 1, "R1 fw first word");
    access(1, 16'h17FF, 1, "R1 fw last word");
    access(1, 16'h0FFF, 0, "R4 below fw");
    access(1, 16'h1800, 0, "R4 above fw");
    access(0, 16'h1000, 0, "R4 data read in fw");
    reg_expect(2'd3, 32'd1, "R8 flag after fw block");

    reg_write(2'd1, 32'h4000);
    reg_write(2'd2, 32'h40FF);
    reg_expect(2'd1, 32'h4000, "R7 lower writable");
    reg_expect(2'd2, 32'h40FF, "R7 upper writable");
    access(1, 16'h4010, 0, "R3 range before enable");

    reg_write(2'd0, 32'd1);
    reg_expect(2'd0, 32'd1, "R6 enable set");
    access(1, 16'h4000, 1, "R2 range low end");
    access(1, 16'h40FF, 1, "R2 range high end");
    access(1, 16'h3FFF, 0, "R2 below range");
    access(1, 16'h4100, 0, "R2 above range");
    access(0, 16'h4010, 0, "R4 data read in range");
    access(1, 16'h1400, 1, "R1 fw with enable");

    reg_write(2'd0, 32'd0);
    reg_expect(2'd0, 32'd1, "R6 enable not cleared");
    reg_write(2'd1, 32'h0000);
    reg_write(2'd2, 32'hFFFF);
    reg_expect(2'd1, 32'h4000, "R7 lower locked");
    reg_expect(2'd2, 32'h40FF, "R7 upper locked");
    access(1, 16'h4100, 0, "R7 locked range unchanged");
    reg_expect(2'd3, 32'd1, "R8 flag still set");

    do_reset();
    reg_expect(2'd3, 32'd0, "R8 flag cleared by reset");
    reg_expect(2'd0, 32'd0, "R9 enable cleared by reset");

    reg_write(2'd1, 32'h5000);
    reg_write(2'd2, 32'h4000);
    reg_write(2'd0, 32'd1);
    access(1, 16'h4000, 0, "R5 inverted upper");
    access(1, 16'h4800, 0, "R5 inverted middle");
    access(1, 16'h5000, 0, "R5 inverted lower");
    reg_expect(2'd3, 32'd0, "R5 no flag from inverted range");

    repeat (2) @(negedge clk);
    note(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule